// File: doc/BRIEF.md
# Decode-Stage Static Branch Redirect Unit

This unit belongs to a pipelined front end whose fetch stage always runs down the sequential path (PC+4), because fetch cannot yet tell a control-transfer instruction from any other and has no target for it. Once an instruction reaches decode, its class and immediate are known. This unit looks at that instruction and decides whether to turn fetch toward a new address one stage early, without waiting for execute.

The policy depends only on the sign of the offset. A conditional branch whose offset is negative (a loop back-edge) is guessed taken. One with a zero or positive offset is guessed not taken. A direct jump's target is fully known in decode, so it always redirects. A register-indirect jump needs a register value that is only ready in execute, so this unit never redirects for it. An early redirect still costs one slot: the instruction fetched behind the branch is squashed. Each instruction's guess is registered and handed to execute, which can compare it against the real outcome. A redirect from execute in the same cycle wins over the decode redirect.

Top module: `decode_redirect_unit`

## Requirements
- R1: While reset is asserted (rst_n low), ex_tag_valid_o and ex_tag_taken_o are 0.
- R2: A valid conditional branch (class code 1) whose offset has its sign bit (bit 31) set raises redir_valid_o in the same cycle. The target is dec_pc_i + dec_imm_i, modulo 2^32.
- R3: A conditional branch whose offset is zero or positive (sign bit clear) never raises redir_valid_o.
- R4: A valid direct jump (class code 2) raises redir_valid_o whatever the offset's sign. The target is dec_pc_i + dec_imm_i.
- R5: A register-indirect jump (class code 3) and any other instruction (class code 0) never raise redir_valid_o.
- R6: When dec_valid_i is 0, redir_valid_o stays 0.
- R7: When ex_redirect_i is 1, redir_valid_o and squash_o are 0 in that cycle. The held-slot memory of R8 is also cleared, so a still-stalled instruction may redirect in the next cycle.
- R8: While dec_stall_i holds one instruction in decode, it redirects at most once, in the first eligible cycle. The instruction that follows once the stall ends may redirect normally.
- R9: After a clock edge with dec_stall_i=0 and ex_redirect_i=0, ex_tag_valid_o equals the old dec_valid_i and ex_tag_taken_o equals the old redirect-eligibility (R2/R4 condition). After an edge with a stall or an execute redirect, both are 0.
- R10: squash_o equals redir_valid_o in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid_i | input | 1 | Decode slot holds an instruction |
| dec_stall_i | input | 1 | Decode slot is held this cycle |
| dec_class_i | input | 2 | 0 other, 1 conditional branch, 2 direct jump, 3 indirect jump |
| dec_pc_i | input | 32 | PC of the decode instruction |
| dec_imm_i | input | 32 | Sign-extended byte offset |
| ex_redirect_i | input | 1 | Execute-stage redirect (overrides, flushes decode) |
| redir_valid_o | output | 1 | Redirect fetch this cycle |
| redir_target_o | output | 32 | Redirect address |
| squash_o | output | 1 | Kill the younger fetched instruction |
| ex_tag_valid_o | output | 1 | Tag stage holds an instruction |
| ex_tag_taken_o | output | 1 | Predicted direction carried to execute |

## Verification
The only internal state that affects redirects is the one-bit "already redirected" memory for a held slot. If it sticks high, a fresh backward branch or jump shows no redirect in its first cycle. If it fails to set, a stalled instruction redirects a second time on the very next cycle. Both show up at redir_valid_o within one cycle of the stall pattern. A wrong tag register shows up at ex_tag_valid_o or ex_tag_taken_o exactly one edge after the instruction leaves decode, or as a non-bubble after a stall.

// File: rtl/dru_pkg.sv
// Shared types for the decode redirect unit.
// Assumes a two-bit instruction class coming from the decoder.
package dru_pkg;

    // Instruction class as delivered by the decoder
    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_COND  = 2'd1,
        CLS_JDIR  = 2'd2,
        CLS_JIND  = 2'd3
    } instr_cls_e;

    localparam int unsigned CLS_W = 2;

endpackage

// File: rtl/dru_predict.sv
// Direction predictor and target adder for the instruction in decode.
// Produces a redirect-eligibility flag and the target PC+offset.
// Assumes the offset is already sign-extended to XLEN bits.
module dru_predict
    import dru_pkg::*;
#(
    parameter int unsigned XLEN           = 32,
    parameter bit          BACKWARD_TAKEN = 1'b1
) (
    input  logic             valid_i,
    input  logic [CLS_W-1:0] cls_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  imm_i,
    output logic             want_o,
    output logic [XLEN-1:0]  target_o
);

    localparam int unsigned SIGN_BIT = XLEN - 1;

    instr_cls_e cls;
    logic       cond_take;

    // Cast the raw class bits into the enum
    always_comb cls = instr_cls_e'(cls_i);

    // Pick the conditional-branch policy at elaboration time
    generate
        if (BACKWARD_TAKEN) begin : g_btfn
            // Backward offsets (sign set) are guessed taken
            always_comb cond_take = imm_i[SIGN_BIT];
        end else begin : g_never
            logic unused_sign;
            // Conditional branches are never guessed taken
            always_comb begin
                unused_sign = imm_i[SIGN_BIT];
                cond_take   = 1'b0;
            end
        end
    endgenerate

    // Decide whether the decode instruction wants to steer fetch
    always_comb begin
        unique case (cls)
            CLS_COND: want_o = valid_i & cond_take;
            CLS_JDIR: want_o = valid_i;
            CLS_JIND: want_o = 1'b0;
            default:  want_o = 1'b0;
        endcase
    end

    // PC-relative target, wrapping modulo 2^XLEN
    always_comb target_o = pc_i + imm_i;

endmodule

// File: rtl/dru_guard.sv
// One-shot guard for a decode slot that is held by a stall.
// Lets the slot redirect once, remembers that, and forgets on
// advance or on an execute flush. Assumes stall means the same
// instruction stays in decode next cycle.
module dru_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic stall_i,
    input  logic flush_i,
    output logic fire_o
);

    logic done_q;

    // Issue a redirect unless overridden or already issued for this slot
    always_comb fire_o = want_i & ~flush_i & ~done_q;

    // Remember an issued redirect while the slot stays held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= stall_i & ~flush_i & (done_q | fire_o);
        end
    end

endmodule

// File: rtl/dru_tag_stage.sv
// Register that carries the predicted direction into execute.
// Inserts a bubble when decode stalls or execute flushes.
module dru_tag_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic stall_i,
    input  logic flush_i,
    input  logic valid_i,
    input  logic pred_i,
    output logic tag_valid_o,
    output logic tag_taken_o
);

    // Advance the tag or drop a bubble into execute
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_valid_o <= 1'b0;
            tag_taken_o <= 1'b0;
        end else if (stall_i || flush_i) begin
            tag_valid_o <= 1'b0;
            tag_taken_o <= 1'b0;
        end else begin
            tag_valid_o <= valid_i;
            tag_taken_o <= pred_i;
        end
    end

endmodule

// File: rtl/decode_redirect_unit.sv
// Decode-stage static redirect unit. It redirects fetch for
// backward conditional branches and direct jumps, squashes the
// younger fetched slot, and hands the guessed direction to execute.
// Assumes that fetch guesses sequential flow and that an execute
// redirect flushes decode.
module decode_redirect_unit
    import dru_pkg::*;
#(
    parameter int unsigned XLEN           = 32,
    parameter bit          BACKWARD_TAKEN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid_i,
    input  logic             dec_stall_i,
    input  logic [CLS_W-1:0] dec_class_i,
    input  logic [XLEN-1:0]  dec_pc_i,
    input  logic [XLEN-1:0]  dec_imm_i,
    input  logic             ex_redirect_i,
    output logic             redir_valid_o,
    output logic [XLEN-1:0]  redir_target_o,
    output logic             squash_o,
    output logic             ex_tag_valid_o,
    output logic             ex_tag_taken_o
);

    logic want;
    logic fire;

    dru_predict #(
        .XLEN           (XLEN),
        .BACKWARD_TAKEN (BACKWARD_TAKEN)
    ) u_predict (
        .valid_i  (dec_valid_i),
        .cls_i    (dec_class_i),
        .pc_i     (dec_pc_i),
        .imm_i    (dec_imm_i),
        .want_o   (want),
        .target_o (redir_target_o)
    );

    dru_guard u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_i  (want),
        .stall_i (dec_stall_i),
        .flush_i (ex_redirect_i),
        .fire_o  (fire)
    );

    dru_tag_stage u_tag (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_i     (dec_stall_i),
        .flush_i     (ex_redirect_i),
        .valid_i     (dec_valid_i),
        .pred_i      (want),
        .tag_valid_o (ex_tag_valid_o),
        .tag_taken_o (ex_tag_taken_o)
    );

    // Fetch redirect and younger-slot kill travel together
    always_comb begin
        redir_valid_o = fire;
        squash_o      = fire;
    end

endmodule

// File: rtl/decode_redirect_unit_chk.sv
// Property checker for decode_redirect_unit, attached by bind.
module decode_redirect_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dec_valid_i,
    input logic       dec_stall_i,
    input logic [1:0] dec_class_i,
    input logic       imm_sign,
    input logic       ex_redirect_i,
    input logic       redir_valid_o,
    input logic       squash_o,
    input logic       ex_tag_valid_o,
    input logic       ex_tag_taken_o
);

    // R10
    squash_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o == redir_valid_o);

    // R6
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |-> !redir_valid_o);

    // R7
    ex_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_redirect_i |-> !redir_valid_o);

    // R8
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stall_i && redir_valid_o) |=> !redir_valid_o);

    // R5
    indirect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_class_i == 2'd3 || dec_class_i == 2'd0) |-> !redir_valid_o);

    // R3
    forward_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_class_i == 2'd1 && !imm_sign) |-> !redir_valid_o);

    // R2
    backward_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && dec_class_i == 2'd1 && imm_sign && !ex_redirect_i
         && !$past(dec_stall_i)) |-> redir_valid_o);

    // R4
    jump_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && dec_class_i == 2'd2 && !ex_redirect_i
         && !$past(dec_stall_i)) |-> redir_valid_o);

    // R9
    stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stall_i |=> (!ex_tag_valid_o && !ex_tag_taken_o));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!ex_tag_valid_o && !ex_tag_taken_o));

endmodule

bind decode_redirect_unit decode_redirect_unit_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dec_valid_i    (dec_valid_i),
    .dec_stall_i    (dec_stall_i),
    .dec_class_i    (dec_class_i),
    .imm_sign       (dec_imm_i[XLEN-1]),
    .ex_redirect_i  (ex_redirect_i),
    .redir_valid_o  (redir_valid_o),
    .squash_o       (squash_o),
    .ex_tag_valid_o (ex_tag_valid_o),
    .ex_tag_taken_o (ex_tag_taken_o)
);

// File: tb/decode_redirect_unit_test.sv
`timescale 1ns/1ps
module decode_redirect_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        dec_valid_i;
    logic        dec_stall_i;
    logic [1:0]  dec_class_i;
    logic [31:0] dec_pc_i;
    logic [31:0] dec_imm_i;
    logic        ex_redirect_i;
    logic        redir_valid_o;
    logic [31:0] redir_target_o;
    logic        squash_o;
    logic        ex_tag_valid_o;
    logic        ex_tag_taken_o;

    always #2.5 clk = ~clk;

    decode_redirect_unit uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .dec_valid_i    (dec_valid_i),
        .dec_stall_i    (dec_stall_i),
        .dec_class_i    (dec_class_i),
        .dec_pc_i       (dec_pc_i),
        .dec_imm_i      (dec_imm_i),
        .ex_redirect_i  (ex_redirect_i),
        .redir_valid_o  (redir_valid_o),
        .redir_target_o (redir_target_o),
        .squash_o       (squash_o),
        .ex_tag_valid_o (ex_tag_valid_o),
        .ex_tag_taken_o (ex_tag_taken_o)
    );

    typedef struct {
        logic        redir;
        logic [31:0] target;
        logic        tag_v;
        logic        tag_t;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   errors   = 0;
    int   checks   = 0;
    bit   finished = 1'b0;

    // reference state kept from the requirements
    logic m_done = 1'b0;
    logic m_tv   = 1'b0;
    logic m_tt   = 1'b0;

    // Driver: apply one decode slot at a negedge, queue expectations
    task automatic step(input logic v, input logic st, input logic [1:0] cls,
                        input logic [31:0] pc, input logic [31:0] imm,
                        input logic exr, input string req);
        exp_t e;
        logic want;
        @(negedge clk);
        dec_valid_i   = v;
        dec_stall_i   = st;
        dec_class_i   = cls;
        dec_pc_i      = pc;
        dec_imm_i     = imm;
        ex_redirect_i = exr;
        want     = v & (((cls == 2'd1) & imm[31]) | (cls == 2'd2));
        e.redir  = want & ~exr & ~m_done;
        e.target = pc + imm;
        e.tag_v  = m_tv;
        e.tag_t  = m_tt;
        e.req    = req;
        exp_q.push_back(e);
        m_done = st & ~exr & (m_done | e.redir);
        if (st || exr) begin
            m_tv = 1'b0;
            m_tt = 1'b0;
        end else begin
            m_tv = v;
            m_tt = want;
        end
    endtask

    // Monitor: compare the outputs just after each negedge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (redir_valid_o !== e.redir) begin
                    errors++;
                    $display("FAIL %s redir act=%0b exp=%0b", e.req, redir_valid_o, e.redir);
                end
                // R10 squash follows redirect
                checks++;
                if (squash_o !== e.redir) begin
                    errors++;
                    $display("FAIL R10 squash act=%0b exp=%0b", squash_o, e.redir);
                end
                if (e.redir) begin
                    checks++;
                    if (redir_target_o !== e.target) begin
                        errors++;
                        $display("FAIL %s target act=%h exp=%h", e.req, redir_target_o, e.target);
                    end
                end
                // R9 tag carried to execute
                checks++;
                if (ex_tag_valid_o !== e.tag_v || ex_tag_taken_o !== e.tag_t) begin
                    errors++;
                    $display("FAIL R9 tag act=%0b%0b exp=%0b%0b",
                             ex_tag_valid_o, ex_tag_taken_o, e.tag_v, e.tag_t);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        dec_valid_i = 1'b0; dec_stall_i = 1'b0; dec_class_i = 2'd0;
        dec_pc_i = '0; dec_imm_i = '0; ex_redirect_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state of the execute tag
        checks++;
        if (ex_tag_valid_o !== 1'b0 || ex_tag_taken_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 tag act=%0b%0b exp=00", ex_tag_valid_o, ex_tag_taken_o);
        end
        rst_n = 1'b1;

        step(1, 0, 2'd1, 32'h0000_0100, 32'hFFFF_FFF8, 0, "R2");
        step(1, 0, 2'd1, 32'h0000_0010, 32'hFFFF_FFE0, 0, "R2");
        step(1, 0, 2'd1, 32'h0000_0100, 32'h0000_0020, 0, "R3");
        step(1, 0, 2'd1, 32'h0000_0100, 32'h0000_0000, 0, "R3");
        step(1, 0, 2'd2, 32'h0000_0200, 32'h0000_0040, 0, "R4");
        step(1, 0, 2'd2, 32'h0000_0200, 32'hFFFF_FF00, 0, "R4");
        step(1, 0, 2'd3, 32'h0000_0300, 32'hFFFF_FFF0, 0, "R5");
        step(1, 0, 2'd0, 32'h0000_0300, 32'hFFFF_FFF0, 0, "R5");
        step(0, 0, 2'd1, 32'h0000_0400, 32'hFFFF_FFF0, 0, "R6");
        step(0, 0, 2'd2, 32'h0000_0400, 32'h0000_0010, 0, "R6");
        step(1, 0, 2'd1, 32'h0000_0500, 32'hFFFF_FFF0, 1, "R7");
        step(1, 0, 2'd2, 32'h0000_0600, 32'h0000_0008, 0, "R4");
        step(1, 1, 2'd2, 32'h0000_0700, 32'h0000_0080, 0, "R8");
        step(1, 1, 2'd2, 32'h0000_0700, 32'h0000_0080, 0, "R8");
        step(1, 0, 2'd2, 32'h0000_0700, 32'h0000_0080, 0, "R8");
        step(1, 0, 2'd1, 32'h0000_0800, 32'hFFFF_FFFC, 0, "R8");
        step(1, 1, 2'd2, 32'h0000_0900, 32'h0000_0010, 1, "R7");
        step(1, 1, 2'd2, 32'h0000_0900, 32'h0000_0010, 0, "R7");
        step(1, 1, 2'd2, 32'h0000_0900, 32'h0000_0010, 0, "R8");
        step(1, 0, 2'd2, 32'h0000_0900, 32'h0000_0010, 0, "R8");
        step(1, 0, 2'd3, 32'h0000_0A00, 32'h0000_0010, 0, "R5");
        step(0, 0, 2'd0, 32'h0000_0000, 32'h0000_0000, 0, "R6");
        step(0, 0, 2'd0, 32'h0000_0000, 32'h0000_0000, 0, "R6");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule